// File: doc/BRIEF.md
# DS3 Receive Overhead Alarm Monitor

This block sits behind the frame aligner of a DS3 receiver and looks at the overhead bits of each M-frame. For every frame it receives a one-cycle boundary strobe and the extracted X pair, application identification (AIC) bit and three FEBE bits. From these it keeps the far-end receive failure (yellow alarm) state and the latest AIC bit, which marks C-bit parity framing (1) or M13 framing (0). It also counts far-end block error events in a 16-bit counter that saturates.

Other framer logic sends single-cycle event pulses: P-bit error, CP-bit error, LOS, AIS, idle and OOF. These pulses, together with changes of the FERF and AIC state, set interrupt flags. Reading the flags clears them. A small host register port reads the status, the flags, the counter bytes and a read/write enable mask. An interrupt output follows the enabled flags.

Top module: `ds3_oh_monitor`

## Requirements
- R1: A frame with X bits 00 sets the FERF state. A frame with X bits 01 or 10 leaves it unchanged, so an asserted FERF persists.
- R2: A frame with X bits 11 clears the FERF state.
- R3: Every change of the FERF state sets interrupt flag bit 3.
- R4: Each frame captures its AIC bit into status bit 3. A change of that value sets interrupt flag bit 2.
- R5: A frame with FEBE bits 111 leaves the counter unchanged. Status bits 2:0 hold the FEBE bits of the last frame.
- R6: A frame with FEBE bits other than 111 adds one to the counter.
- R7: The counter saturates at 0xFFFF and does not wrap.
- R8: A read of offset 3 returns counter bits 7:0, captures bits 15:8 for later reads of offset 4, and clears the counter. A counted frame in that same cycle leaves the counter at 1.
- R9: Offset 0 reads {3'b000, FERF, AIC, FEBE[2:0]}.
- R10: Offset 1 reads the interrupt flags. The bits from 7 to 0 are CP-bit error, LOS, AIS, idle, FERF, AIC, OOF and P-bit error. Each event pulse sets its bit, and a read of offset 1 clears all flags.
- R11: An event in the same cycle as a read of offset 1 leaves its flag set.
- R12: Offset 2 is the read/write enable mask. irq_o is high exactly when some flag and its enable bit are both 1.
- R13: After reset, all registers read 0 and irq_o is low. Unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe at each received M-frame |
| x_bits_i | input | 2 | X1/X2 overhead bits of the frame |
| aic_i | input | 1 | AIC overhead bit of the frame |
| febe_i | input | 3 | FEBE overhead bits of the frame |
| ev_pbit_i | input | 1 | P-bit error event pulse |
| ev_cpbit_i | input | 1 | CP-bit error event pulse |
| ev_los_i | input | 1 | LOS event pulse |
| ev_ais_i | input | 1 | AIS event pulse |
| ev_idle_i | input | 1 | Idle event pulse |
| ev_oof_i | input | 1 | OOF event pulse |
| addr_i | input | 3 | Host register offset |
| rd_en_i | input | 1 | Host read strobe; side effects occur at the clock edge |
| wr_en_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: byte-wide registers and a 16-bit counter. With these values saturation is reachable through about 65.5k back-to-back errored frames, and the bench drives that run and then reads both counter bytes. Random frames, event pulses, reads and mask writes are compared against a bench model in every cycle. Directed steps cover a flag event that coincides with a flag read, and a counted frame that coincides with a low-byte read.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int FEBE_W = 3;
  localparam int N_FLAG = 8;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_FLAGS  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 3'd4;

  // flag bit positions, fixed by the register layout
  localparam int FL_PBIT  = 0;
  localparam int FL_OOF   = 1;
  localparam int FL_AIC   = 2;
  localparam int FL_FERF  = 3;
  localparam int FL_IDLE  = 4;
  localparam int FL_AIS   = 5;
  localparam int FL_LOS   = 6;
  localparam int FL_CPBIT = 7;
endpackage

// File: rtl/ds3_oh_status.sv
module ds3_oh_status #(
  parameter int FEBE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [1:0]        x_bits_i,
  input  logic              aic_i,
  input  logic [FEBE_W-1:0] febe_i,
  output logic              ferf_o,
  output logic              aic_o,
  output logic [FEBE_W-1:0] febe_o,
  output logic              ferf_chg_o,
  output logic              aic_chg_o
);
  logic ferf_d;

  always_comb begin
    ferf_d = ferf_o;
    if (frame_vld_i) begin
      if (x_bits_i == 2'b00)      ferf_d = 1'b1;
      else if (x_bits_i == 2'b11) ferf_d = 1'b0;
    end
  end

  assign ferf_chg_o = ferf_d != ferf_o;
  assign aic_chg_o  = frame_vld_i && (aic_i != aic_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ferf_o <= 1'b0;
      aic_o  <= 1'b0;
      febe_o <= '0;
    end else begin
      ferf_o <= ferf_d;
      if (frame_vld_i) begin
        aic_o  <= aic_i;
        febe_o <= febe_i;
      end
    end
  end

  a_r1_ferf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && x_bits_i == 2'b00 |=> ferf_o);
  a_r1_ferf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && (x_bits_i == 2'b01 || x_bits_i == 2'b10) |=> $stable(ferf_o));
  a_r2_ferf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && x_bits_i == 2'b11 |=> !ferf_o);
  a_r4_aic_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> aic_o == $past(aic_i));
endmodule

// File: rtl/ds3_febe_counter.sv
module ds3_febe_counter #(
  parameter int FEBE_W = 3,
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [FEBE_W-1:0] febe_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] hi_snap_o
);
  logic err, inc;

  assign err = frame_vld_i && (febe_i != {FEBE_W{1'b1}});
  assign inc = err && (clr_i || cnt_o != {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      hi_snap_o <= '0;
    end else if (clr_i) begin
      hi_snap_o <= cnt_o[CNT_W-1:DATA_W];
      cnt_o     <= {{(CNT_W-1){1'b0}}, inc};
    end else if (inc) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  a_r5_clean_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && febe_i == {FEBE_W{1'b1}} && !clr_i |=> $stable(cnt_o));
  a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == {CNT_W{1'b1}} && !clr_i |=> cnt_o == {CNT_W{1'b1}});
  a_r8_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o <= 1 && hi_snap_o == $past(cnt_o[CNT_W-1:DATA_W]));
endmodule

// File: rtl/ds3_irq_regs.sv
module ds3_irq_regs #(
  parameter int N_FLAG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FLAG-1:0] ev_i,
  input  logic              clr_i,
  input  logic              en_wr_i,
  input  logic [N_FLAG-1:0] en_wdata_i,
  output logic [N_FLAG-1:0] flags_o,
  output logic [N_FLAG-1:0] en_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      en_o    <= '0;
    end else begin
      flags_o <= (clr_i ? '0 : flags_o) | ev_i;
      if (en_wr_i) en_o <= en_wdata_i;
    end
  end

  assign irq_o = |(flags_o & en_o);

  a_r11_event_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |ev_i |=> (flags_o & $past(ev_i)) == $past(ev_i));
  a_r10_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && ev_i == '0 |=> flags_o == '0);
  a_r12_no_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i && en_wdata_i == '0 |=> !irq_o);
endmodule

// File: rtl/ds3_oh_monitor.sv
module ds3_oh_monitor
  import ds3_oh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [1:0]        x_bits_i,
  input  logic              aic_i,
  input  logic [2:0]        febe_i,
  input  logic              ev_pbit_i,
  input  logic              ev_cpbit_i,
  input  logic              ev_los_i,
  input  logic              ev_ais_i,
  input  logic              ev_idle_i,
  input  logic              ev_oof_i,
  input  logic [2:0]        addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic              ferf, aic, ferf_chg, aic_chg;
  logic [FEBE_W-1:0] febe_last;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hi_snap;
  logic [N_FLAG-1:0] ev, flags, en;
  logic              rd_lo, rd_flags, wr_en_reg;

  assign rd_lo     = rd_en_i && addr_i == OFF_CNT_LO;
  assign rd_flags  = rd_en_i && addr_i == OFF_FLAGS;
  assign wr_en_reg = wr_en_i && addr_i == OFF_ENABLE;

  always_comb begin
    ev           = '0;
    ev[FL_PBIT]  = ev_pbit_i;
    ev[FL_OOF]   = ev_oof_i;
    ev[FL_AIC]   = aic_chg;
    ev[FL_FERF]  = ferf_chg;
    ev[FL_IDLE]  = ev_idle_i;
    ev[FL_AIS]   = ev_ais_i;
    ev[FL_LOS]   = ev_los_i;
    ev[FL_CPBIT] = ev_cpbit_i;
  end

  ds3_oh_status #(.FEBE_W(FEBE_W)) u_status (
    .clk_i, .rst_ni, .frame_vld_i, .x_bits_i, .aic_i, .febe_i,
    .ferf_o(ferf), .aic_o(aic), .febe_o(febe_last),
    .ferf_chg_o(ferf_chg), .aic_chg_o(aic_chg)
  );

  ds3_febe_counter #(.FEBE_W(FEBE_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .frame_vld_i, .febe_i, .clr_i(rd_lo),
    .cnt_o(cnt), .hi_snap_o(hi_snap)
  );

  ds3_irq_regs #(.N_FLAG(N_FLAG)) u_irq (
    .clk_i, .rst_ni, .ev_i(ev), .clr_i(rd_flags), .en_wr_i(wr_en_reg),
    .en_wdata_i(wdata_i), .flags_o(flags), .en_o(en), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      OFF_STATUS: rdata_o = {3'b000, ferf, aic, febe_last};
      OFF_FLAGS:  rdata_o = flags;
      OFF_ENABLE: rdata_o = en;
      OFF_CNT_LO: rdata_o = cnt[DATA_W-1:0];
      OFF_CNT_HI: rdata_o = hi_snap;
      default:    rdata_o = '0;
    endcase
  end

  a_r3_ferf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferf != $past(ferf) |-> flags[FL_FERF]);
  a_r9_status_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFF_STATUS |-> rdata_o[7:5] == 3'b000);
endmodule

// File: tb/ds3_oh_monitor_bench.sv
module ds3_oh_monitor_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 0, a_bit = 0, rd = 0, wr = 0;
  logic [1:0] xb = 0;
  logic [2:0] fb = 0, addr = 0;
  logic [7:0] ev8 = 0, wd = 0, rdata;
  logic irq;

  int n_chk = 0, n_err = 0;

  // bench model
  logic m_ferf = 0, m_aic = 0;
  logic [2:0] m_febe = 0;
  logic [7:0] m_flags = 0, m_en = 0, m_snap = 0;
  logic [15:0] m_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  ds3_oh_monitor u_ds3_oh_monitor (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(fv), .x_bits_i(xb), .aic_i(a_bit),
    .febe_i(fb), .ev_pbit_i(ev8[0]), .ev_cpbit_i(ev8[7]), .ev_los_i(ev8[6]),
    .ev_ais_i(ev8[5]), .ev_idle_i(ev8[4]), .ev_oof_i(ev8[1]), .addr_i(addr),
    .rd_en_i(rd), .wr_en_i(wr), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_rd(input logic [2:0] ad);
    case (ad)
      3'd0: return {3'b000, m_ferf, m_aic, m_febe};
      3'd1: return m_flags;
      3'd2: return m_en;
      3'd3: return m_cnt[7:0];
      3'd4: return m_snap;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] ad);
    case (ad)
      3'd0: return "R9/R1/R2/R4/R5";
      3'd1: return "R10/R11/R3/R4";
      3'd2: return "R12";
      3'd3: return "R6/R7/R8";
      3'd4: return "R8/R7";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", r, act, exp);
    end
  endtask

  // one clock cycle of stimulus; model follows the requirements
  task automatic step(input logic f_v, input logic [1:0] x, input logic a,
                      input logic [2:0] f, input logic [7:0] e, input logic r,
                      input logic w, input logic [2:0] ad, input logic [7:0] d);
    logic nferf, inc, clr;
    @(negedge clk);
    check("R12 irq", {7'b0, irq}, {7'b0, |(m_flags & m_en)});
    fv = f_v; xb = x; a_bit = a; fb = f; ev8 = e & 8'hF3;
    rd = r; wr = w; addr = ad; wd = d;
    #1;
    if (r) check(req_of(ad), rdata, exp_rd(ad));
    nferf = m_ferf;
    if (f_v && x == 2'b00) nferf = 1'b1;
    if (f_v && x == 2'b11) nferf = 1'b0;
    clr = r && ad == 3'd3;
    inc = f_v && f != 3'b111 && (clr || m_cnt != 16'hFFFF);
    m_flags = (r && ad == 3'd1) ? 8'h00 : m_flags;
    m_flags = m_flags | (e & 8'hF3) | {4'b0, nferf != m_ferf, f_v && a != m_aic, 2'b0};
    m_ferf = nferf;
    if (f_v) begin m_aic = a; m_febe = f; end
    if (clr) begin m_snap = m_cnt[15:8]; m_cnt = {15'b0, inc}; end
    else if (inc) m_cnt = m_cnt + 1'b1;
    if (w && ad == 3'd2) m_en = d;
  endtask

  task automatic frm(input logic [1:0] x, input logic a, input logic [2:0] f);
    step(1, x, a, f, 0, 0, 0, 0, 0);
  endtask

  task automatic rdr(input logic [2:0] ad);
    step(0, 0, 0, 0, 0, 1, 0, ad, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_P * 3) rst_n = 1'b1;
    // R13 reset state
    for (int i = 0; i < 8; i++) rdr(3'(i));
    // R1 set, hold on mixed X, R2 clear, R3 flag
    frm(2'b00, 0, 3'b111);
    rdr(0); rdr(1);
    frm(2'b01, 0, 3'b111); frm(2'b10, 0, 3'b111);
    rdr(0); rdr(1);
    frm(2'b11, 0, 3'b111);
    rdr(0); rdr(1);
    // R4 AIC capture and change flag
    frm(2'b11, 1, 3'b111); rdr(0); rdr(1);
    frm(2'b11, 1, 3'b111); rdr(1);
    // R5 / R6 counting
    frm(2'b11, 1, 3'b011); frm(2'b11, 1, 3'b111); frm(2'b11, 1, 3'b000);
    rdr(0); rdr(3); rdr(4); rdr(3);
    // R8 counted frame together with low-byte read
    frm(2'b11, 1, 3'b101); frm(2'b11, 1, 3'b101);
    step(1, 2'b11, 1, 3'b110, 0, 1, 0, 3'd3, 0);
    rdr(3);
    // R11 event during flag read
    step(0, 0, 0, 0, 8'h81, 0, 0, 0, 0);
    step(0, 0, 0, 0, 8'h20, 1, 0, 3'd1, 0);
    rdr(1); rdr(1);
    // R12 enable mask and irq
    step(0, 0, 0, 0, 8'h40, 1, 1, 3'd2, 8'h40);
    rdr(2);
    step(0, 0, 0, 0, 0, 0, 1, 3'd2, 8'h00);
    step(0, 0, 0, 0, 0, 0, 1, 3'd2, 8'hFF);
    rdr(1); rdr(1);
    // R7 saturation
    for (int i = 0; i < 65540; i++) frm(2'b11, 1, 3'b010);
    rdr(3); rdr(4); rdr(3);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ad;
      ad = 3'($urandom_range(0, 5));
      step($urandom_range(0, 2) != 0, 2'($urandom), 1'($urandom_range(0, 9) == 0) ^ m_aic,
           ($urandom_range(0, 1) != 0) ? 3'b111 : 3'($urandom),
           ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00,
           $urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0, ad, 8'($urandom));
    end
    rdr(0); rdr(1); rdr(3); rdr(4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule